// File: doc/BRIEF.md
# Sleep Wakeup Glitch Filter

This block decides when a chip that is in deep sleep should be woken. It watches four digital wakeup sources: one line that merges activity from all general-purpose pins, an activity line from each of two serial controllers, and one external interrupt line. When software enters sleep it pulses a one-cycle strobe. On that strobe the block records the level of every source as a reference, and from then on it looks for a source that has moved away from its recorded level.

Each source can optionally be filtered. A filtered source is sampled only on a slow sampling tick, which comes from a nominal 10 kHz oscillator. It counts as moved only once three successive samples all show the level opposite to the reference. An unfiltered source counts as moved as soon as its level differs from the reference. A per-source select mask decides which sources may wake the chip. A qualifying source raises a single sticky wake request toward the power controller, and that request stays high until a wake acknowledge clears it. The request does not say which pin or source caused it, so software must read the inputs to find out. A pin held in analog mode presents a constant 1 to this block. If it was already 1 when sleep was entered, it never wakes the chip.

Top module: `slpwake_filter`

## Requirements
- R1: After reset `wake_req` is 0, and no input activity raises it until a `sleep_enter` strobe has armed the block.
- R2: A `sleep_enter` strobe records the current level of every source as that source's reference, arms the block, and clears `wake_req` on the following edge. On the cycle after the strobe, `wake_req` is 0.
- R3: With its filter bit clear in `filt_en`, a selected source whose level differs from its reference while the block is armed raises `wake_req` on the next rising clock edge.
- R4: With its filter bit set, a source is sampled only on cycles where `sample_tick` is 1. `wake_req` rises on the edge after the third successive tick sample that is opposite to the reference. Cycles without a tick do not count as samples.
- R5: For a filtered source, a run of opposite samples that is broken by a sample equal to the reference restarts the count. Two opposite samples, one reference sample and two more opposite samples therefore do not wake the chip.
- R6: A source that stays at, or returns to, its reference level never raises `wake_req`. This holds for a pin in analog mode that reads constant 1. It also holds for a filtered source whose last three samples equal the reference.
- R7: A source whose bit in `wake_sel` is 0 never raises `wake_req`, whatever its level.
- R8: `wake_req` stays 1 until `wake_ack` is 1 on a rising edge. After that edge it is 0, and the block is disarmed, so it stays 0 until the next `sleep_enter`.
- R9: When `sleep_enter` and `wake_ack` are both 1 in the same cycle, `sleep_enter` wins: the block is armed afterwards.
- R10: The source bits are fixed as follows: bit 0 is merged pin activity, bit 1 is serial controller 1, bit 2 is serial controller 2 and bit 3 is the external interrupt. Any one selected source is enough to raise the single `wake_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | N_SRC | Wakeup source levels (bit 0 pins, 1 serial 1, 2 serial 2, 3 external interrupt), synchronous to clk |
| filt_en | input | N_SRC | Per-source filter enable, 1 = three-sample filtering |
| wake_sel | input | N_SRC | Per-source wake enable, 1 = source may wake |
| sample_tick | input | 1 | One-cycle slow sampling strobe |
| sleep_enter | input | 1 | One-cycle strobe: record references and arm |
| wake_ack | input | 1 | Clears the wake request and disarms |
| wake_req | output | 1 | Sticky wake request to the power controller |

## Verification
Directed patterns cover several cases. A single unfiltered level change shows whether the design compares against the recorded reference rather than detecting an edge. Three ticked samples spread across idle cycles show whether only tick cycles count toward the filter. A broken run (two opposite samples, one reference sample, two opposite samples) shows whether a glitch restarts the count. A constant-high input recorded at entry shows whether the analog-mode level stays silent. Masked sources, simultaneous strobe and acknowledge, and re-raising after acknowledge probe the select, priority and sticky behaviour. A long random stretch then mixes level flips, irregular ticks, strobes, acknowledges and changing masks, and it is compared cycle by cycle against a run-length model computed in the bench.

// File: rtl/wkf_pkg.sv
// Package: shared constants for the sleep wakeup filter.
// Assumes four wakeup sources with fixed bit positions.
package wkf_pkg;
    localparam int WKF_NSRC   = 4;  // number of wakeup sources
    localparam int WKF_STABLE = 3;  // successive samples needed when filtered
    localparam int WKF_PINS   = 0;  // merged general-purpose pin activity
    localparam int WKF_SER1   = 1;  // serial controller 1 activity
    localparam int WKF_SER2   = 2;  // serial controller 2 activity
    localparam int WKF_EXTIRQ = 3;  // external interrupt line
endpackage

// File: rtl/wkf_channel.sv
// Module: one wakeup source channel.
// Records a reference level on sleep entry and keeps a short history of
// tick samples. Reports "moved" either directly (unfiltered) or once the
// whole history is opposite to the reference (filtered).
// Assumes src is already synchronous to clk and STABLE >= 2.
module wkf_channel #(
    parameter int STABLE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic filt_en,
    input  logic sample_tick,
    input  logic sleep_enter,
    output logic moved
);
    logic              ref_lvl;
    logic [STABLE-1:0] hist;
    logic              hist_flipped;

    // Record the reference at entry; shift in a sample on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_lvl <= 1'b0;
            hist    <= '0;
        end else if (sleep_enter) begin
            ref_lvl <= src;
            hist    <= {STABLE{src}};
        end else if (sample_tick) begin
            hist    <= {hist[STABLE-2:0], src};
        end
    end

    // Decide whether this source has left its reference level.
    always_comb begin
        hist_flipped = (hist == {STABLE{~ref_lvl}});
        moved        = filt_en ? hist_flipped : (src ^ ref_lvl);
    end
endmodule

// File: rtl/wkf_wake_ctl.sv
// Module: arming state and sticky wake request.
// Entry arms the block and clears the request. Acknowledge clears and
// disarms. Entry wins over acknowledge, and acknowledge wins over a new hit.
module wkf_wake_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_enter,
    input  logic wake_ack,
    input  logic hit,
    output logic armed,
    output logic wake_req
);
    // Track whether a sleep period is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)           armed <= 1'b0;
        else if (sleep_enter) armed <= 1'b1;
        else if (wake_ack)    armed <= 1'b0;
    end

    // Raise and hold the wake request until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)             wake_req <= 1'b0;
        else if (sleep_enter)   wake_req <= 1'b0;
        else if (wake_ack)      wake_req <= 1'b0;
        else if (armed && hit)  wake_req <= 1'b1;
    end
endmodule

// File: rtl/slpwake_filter.sv
// Module: top of the sleep wakeup filter.
// Builds one channel per source, masks the channels with wake_sel and
// merges them into a single sticky request. Sources are assumed to be
// synchronous to clk, and sample_tick is assumed to be a one-cycle pulse.
module slpwake_filter
    import wkf_pkg::*;
#(
    parameter int N_SRC  = WKF_NSRC,
    parameter int STABLE = WKF_STABLE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_in,
    input  logic [N_SRC-1:0] filt_en,
    input  logic [N_SRC-1:0] wake_sel,
    input  logic             sample_tick,
    input  logic             sleep_enter,
    input  logic             wake_ack,
    output logic             wake_req
);
    logic [N_SRC-1:0] moved;
    logic [N_SRC-1:0] qualified;
    logic             hit;
    logic             armed;

    // One filtering channel per source.
    for (genvar g = 0; g < N_SRC; g++) begin : g_chan
        wkf_channel #(.STABLE(STABLE)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .src         (src_in[g]),
            .filt_en     (filt_en[g]),
            .sample_tick (sample_tick),
            .sleep_enter (sleep_enter),
            .moved       (moved[g])
        );
    end

    // Keep only selected sources and merge them.
    always_comb begin
        qualified = moved & wake_sel;
        hit       = |qualified;
    end

    wkf_wake_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_enter (sleep_enter),
        .wake_ack    (wake_ack),
        .hit         (hit),
        .armed       (armed),
        .wake_req    (wake_req)
    );
endmodule

// File: rtl/wkf_checker.sv
// Module: assertion checker for slpwake_filter, attached by bind.
// Observes the top-level ports and the internal arming flag.
module wkf_checker #(
    parameter int N_SRC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_enter,
    input logic             wake_ack,
    input logic [N_SRC-1:0] wake_sel,
    input logic             armed,
    input logic             wake_req
);
    // R2: entry clears the request.
    a_r2_entry_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_enter |=> !wake_req);

    // R9: entry always leaves the block armed.
    a_r9_entry_arms: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_enter |=> armed);

    // R8: acknowledge without entry clears the request.
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_ack && !sleep_enter) |=> !wake_req);

    // R8: the request holds until acknowledged or re-entered.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !wake_ack && !sleep_enter) |=> wake_req);

    // R1: the request can only rise while armed.
    a_r1_needs_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> $past(armed));

    // R7: the request can only rise if some source was selected.
    a_r7_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> ($past(wake_sel) != '0));
endmodule

bind slpwake_filter wkf_checker #(.N_SRC(N_SRC)) u_wkf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_enter (sleep_enter),
    .wake_ack    (wake_ack),
    .wake_sel    (wake_sel),
    .armed       (armed),
    .wake_req    (wake_req)
);

// File: tb/test_slpwake_filter.sv
module test_slpwake_filter;
    localparam int NS = 4;
    localparam int ST = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_in = '0;
    logic [NS-1:0] filt_en = '0;
    logic [NS-1:0] wake_sel = '0;
    logic          sample_tick = 1'b0;
    logic          sleep_enter = 1'b0;
    logic          wake_ack = 1'b0;
    logic          wake_req;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Bench reference model state.
    logic [NS-1:0] m_ref = '0;
    int            m_run [NS];
    bit            m_armed = 1'b0;
    bit            m_req = 1'b0;

    always #2 clk = ~clk;

    slpwake_filter #(.N_SRC(NS), .STABLE(ST)) i_slpwake_filter (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .filt_en(filt_en),
        .wake_sel(wake_sel), .sample_tick(sample_tick),
        .sleep_enter(sleep_enter), .wake_ack(wake_ack), .wake_req(wake_req)
    );

    // Model one clock edge from the requirements (run-length counters).
    task automatic model_edge();
        bit hit = 1'b0;
        for (int i = 0; i < NS; i++) begin
            bit mv = filt_en[i] ? (m_run[i] >= ST) : (src_in[i] != m_ref[i]);
            if (mv && wake_sel[i]) hit = 1'b1;
        end
        if (sleep_enter) begin
            m_armed = 1'b1; m_req = 1'b0; m_ref = src_in;
            for (int i = 0; i < NS; i++) m_run[i] = 0;
        end else begin
            if (wake_ack) begin m_req = 1'b0; m_armed = 1'b0; end
            else if (m_armed && hit) m_req = 1'b1;
            if (sample_tick)
                for (int i = 0; i < NS; i++)
                    m_run[i] = (src_in[i] != m_ref[i]) ? ((m_run[i] < ST) ? m_run[i] + 1 : ST) : 0;
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
        end
    endtask

    task automatic check(input string tag, input logic exp);
        tests++;
        if (wake_req !== exp) begin
            fails++;
            $display("FAIL %s: wake_req=%0b expected %0b", tag, wake_req, exp);
        end
    endtask

    task automatic enter();
        sleep_enter = 1'b1; step(1); sleep_enter = 1'b0;
    endtask

    task automatic ack();
        wake_ack = 1'b1; step(1); wake_ack = 1'b0;
    endtask

    task automatic tick();
        sample_tick = 1'b1; step(1); sample_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < NS; i++) m_run[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset value", 1'b0);

        // R1: activity before any entry is ignored.
        wake_sel = 4'hF; src_in = 4'hF; step(3);
        check("R1 not armed", 1'b0);

        // R3: unfiltered change against the reference.
        src_in = 4'h0; enter();
        check("R2 after entry", 1'b0);
        src_in[1] = 1'b1; step(1);
        check("R3 unfiltered rise", 1'b1);

        // R8: sticky, then cleared, then no re-raise.
        src_in = 4'h0; step(3);
        check("R8 sticky", 1'b1);
        ack();
        check("R8 ack clears", 1'b0);
        src_in[1] = 1'b1; step(3);
        check("R8 disarmed", 1'b0);

        // R2: entry clears a pending request and takes a new reference.
        src_in = 4'h0; enter(); src_in[2] = 1'b1; step(1);
        check("R2 setup", 1'b1);
        enter();
        check("R2 entry clears", 1'b0);
        src_in[2] = 1'b0; step(1);
        check("R2 new reference", 1'b1);

        // R9: entry and ack together arm.
        src_in = 4'h0; sleep_enter = 1'b1; wake_ack = 1'b1; step(1);
        sleep_enter = 1'b0; wake_ack = 1'b0;
        check("R9 both strobes", 1'b0);
        src_in[3] = 1'b1; step(1);
        check("R9 still armed", 1'b1);

        // R7 and R10: masked pin source, then external interrupt bit 3.
        ack(); src_in = 4'h0; wake_sel = 4'b1110; enter();
        src_in[0] = 1'b1; step(3);
        check("R7 masked source", 1'b0);
        src_in[3] = 1'b1; step(1);
        check("R10 bit3 external interrupt", 1'b1);

        // R4: three tick samples, spread over idle cycles.
        ack(); src_in = 4'h0; wake_sel = 4'hF; filt_en = 4'hF; enter();
        src_in[2] = 1'b1;
        tick(); check("R4 one sample", 1'b0);
        tick(); step(3); check("R4 no tick no count", 1'b0);
        tick(); check("R4 third sample edge", 1'b0);
        step(1); check("R4 wake after third", 1'b1);

        // R5: broken run restarts the count.
        ack(); src_in = 4'h0; enter();
        src_in[0] = 1'b1; tick(); tick();
        src_in[0] = 1'b0; tick();
        src_in[0] = 1'b1; tick(); tick(); step(2);
        check("R5 glitch restarts", 1'b0);
        tick(); step(1);
        check("R5 third after restart", 1'b1);

        // R6: constant high (analog pin) and return to reference.
        ack(); src_in = 4'hF; filt_en = 4'h0; enter();
        tick(); tick(); tick(); step(2);
        check("R6 analog constant one", 1'b0);
        filt_en = 4'hF; src_in = 4'h0; enter();
        src_in[1] = 1'b1; tick(); tick();
        src_in[1] = 1'b0; tick(); tick(); tick(); step(2);
        check("R6 back at reference", 1'b0);

        // Random stretch against the bench model (R3 R4 R5 R7 R8).
        ack();
        for (int c = 0; c < 4000; c++) begin
            if ($urandom % 8 == 0) src_in[$urandom % NS] ^= 1'b1;
            if ($urandom % 300 == 0) filt_en = 4'($urandom);
            if ($urandom % 300 == 0) wake_sel = 4'($urandom);
            sample_tick = ($urandom % 5 == 0);
            sleep_enter = ($urandom % 120 == 0);
            wake_ack    = ($urandom % 70 == 0);
            step(1);
            tests++;
            if (wake_req !== m_req) begin
                fails++;
                $display("FAIL R4 random cycle %0d: wake_req=%0b expected %0b", c, wake_req, m_req);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule